// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is a bus master for a three-wire serial EEPROM. It drives the select, serial clock and serial data-out lines, and it samples the returned data line. Through a simple request interface it runs single-word writes, single-word reads and multi-word burst reads. The serial clock comes from the system clock through a divider whose half period is a parameter.

A user asserts `req_valid` with an operation, an address, write data and a burst length. The request is taken on the cycle where `req_ready` is also high. Each word that comes back is presented on `rd_data` with a one-cycle `rd_valid` strobe. The end of every request is marked by a one-cycle `done`.

Before the first write after reset, the controller sends an unlock command once. A write ends with a minimum deselect interval. After that the controller selects the memory again without clocking it and watches the data line until the memory reports ready. If ready does not arrive within a parameterized number of cycles, `err` is raised together with `done`.

Top module: `uwire_eeprom_host`

## Requirements
- R1: After reset, `mem_sel`, `mem_clk`, `rd_valid`, `done` and `err` are low and `req_ready` is high.
- R2: Every command starts with a 1 bit, then a 2-bit opcode, then the address MSB first. The opcode is 10 for read, 01 for write and 00 for unlock. For a write, the data word follows MSB first. `mem_mosi` changes only while `mem_clk` is low or on its falling edge, and it is stable while `mem_clk` is high.
- R3: `mem_clk` stays high for exactly HALF_DIV system clocks in each bit period and low for HALF_DIV, and it is low whenever `mem_sel` is low.
- R4: In a read, the bit sampled in the clock period of the last address bit is a dummy 0 and is discarded. The data bits that follow are assembled MSB first, and each word is presented with a single-cycle `rd_valid`.
- R5: A read delivers `req_len`+1 words with `mem_sel` held high and the clock running. Only the first word has a dummy bit before it. The memory wraps its address from the top to 0, so words past the top come from address 0 upward.
- R6: The unlock command (opcode 00, address starting with bits 11, remaining bits 0) is sent exactly once, before the first write after reset, and never again.
- R7: After the last write data bit, `mem_sel` goes low for at least DESEL_CLKS clocks. It then goes high with `mem_clk` idle while `mem_miso` is sampled: low means busy and high means ready. When ready is seen, `mem_sel` drops and `done` follows with `err` low. `done` never comes while the memory is still busy.
- R8: If ready is not seen within POLL_LIMIT clocks of polling, the poll is abandoned and `err` pulses together with `done`.
- R9: `req_ready` is high only while the controller is idle with `mem_sel` low. Each accepted request produces exactly one single-cycle `done`, and `done` is issued with `mem_sel` low.
- R10: Every low interval of `mem_sel` between selections lasts at least DESEL_CLKS system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when both high |
| req_op | input | 1 | 0 read, 1 write |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_len | input | LEN_W | Read words minus one |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DATA_W | Read word |
| done | output | 1 | Request finished |
| err | output | 1 | Ready poll timed out, valid with done |
| mem_sel | output | 1 | Memory select |
| mem_clk | output | 1 | Serial clock |
| mem_mosi | output | 1 | Serial data to memory |
| mem_miso | input | 1 | Serial data and ready status from memory |

## Verification
A wrong bit counter or shift register shows up as a misframed command. The memory model then decodes the wrong address or opcode, and the next read-back word miscompares within one transaction. A dummy-bit error shifts every read word by one bit on its very first `rd_valid`. A poll that ignores the line, or a gap counter that is off, makes `done` arrive while the model is still busy, or shortens a deselect interval. Either is caught at that same `done` or at the next rise of select.

// File: rtl/uwire_eeprom_host.sv
module uwire_eeprom_host #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 4,
  parameter int HALF_DIV   = 2,
  parameter int DESEL_CLKS = 4,
  parameter int POLL_LIMIT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              mem_sel,
  output logic              mem_clk,
  output logic              mem_mosi,
  input  logic              mem_miso
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int FRAME_W  = CMD_BITS + DATA_W;
  localparam int BC_W     = $clog2(FRAME_W);
  localparam int HD_W     = $clog2(HALF_DIV + 1);
  localparam int TMAX     = (POLL_LIMIT > DESEL_CLKS) ? POLL_LIMIT : DESEL_CLKS;
  localparam int TM_W     = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] UNLOCK_ADDR = {2'b11, {(ADDR_W-2){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_READ, S_GAP, S_POLL} st_t;
  typedef enum logic [1:0] {N_WRITE, N_POLL, N_END} nx_t;

  st_t               st;
  nx_t               nx;
  logic              sel_q, clk_q, op_wr, unlocked, err_f;
  logic [HD_W-1:0]   dcnt;
  logic [FRAME_W-1:0] tx;
  logic [BC_W-1:0]   bcnt;
  logic [LEN_W-1:0]  wcnt;
  logic [DATA_W-1:0] rx, wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TM_W-1:0]   tmr;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] op,
                                                  input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
    return {1'b1, op, a, d};
  endfunction

  wire tick    = (dcnt == HD_W'(HALF_DIV - 1));
  wire bit_end = tick & clk_q;
  wire running = (st == S_SHIFT) || (st == S_READ);
  wire [DATA_W-1:0] rx_next = {rx[DATA_W-2:0], mem_miso};

  assign req_ready = (st == S_IDLE);
  assign mem_sel   = sel_q;
  assign mem_clk   = clk_q;
  assign mem_mosi  = sel_q & tx[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  nx <= N_END;
      sel_q <= 1'b0; clk_q <= 1'b0; op_wr <= 1'b0; unlocked <= 1'b0; err_f <= 1'b0;
      dcnt <= '0; tx <= '0; bcnt <= '0; wcnt <= '0; rx <= '0; wdata_q <= '0;
      addr_q <= '0; tmr <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      if (running) begin
        if (tick) begin
          dcnt  <= '0;
          clk_q <= ~clk_q;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (req_valid) begin
          op_wr   <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wcnt    <= req_len;
          err_f   <= 1'b0;
          sel_q   <= 1'b1;
          clk_q   <= 1'b0;
          dcnt    <= '0;
          st      <= S_SHIFT;
          if (req_op && !unlocked) begin
            tx   <= mk_frame(2'b00, UNLOCK_ADDR, '0);
            bcnt <= BC_W'(CMD_BITS - 1);
          end else if (req_op) begin
            tx   <= mk_frame(2'b01, req_addr, req_wdata);
            bcnt <= BC_W'(FRAME_W - 1);
          end else begin
            tx   <= mk_frame(2'b10, req_addr, '0);
            bcnt <= BC_W'(CMD_BITS - 1);
          end
        end
        S_SHIFT: if (bit_end) begin
          tx <= tx << 1;
          if (bcnt == '0) begin
            if (op_wr) begin
              sel_q    <= 1'b0;
              tmr      <= '0;
              nx       <= unlocked ? N_POLL : N_WRITE;
              unlocked <= 1'b1;
              st       <= S_GAP;
            end else begin
              bcnt <= BC_W'(DATA_W - 1);
              st   <= S_READ;
            end
          end else begin
            bcnt <= bcnt - 1'b1;
          end
        end
        S_READ: if (bit_end) begin
          rx <= rx_next;
          if (bcnt == '0) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_next;
            bcnt     <= BC_W'(DATA_W - 1);
            if (wcnt == '0) begin
              sel_q <= 1'b0;
              tmr   <= '0;
              nx    <= N_END;
              st    <= S_GAP;
            end else begin
              wcnt <= wcnt - 1'b1;
            end
          end else begin
            bcnt <= bcnt - 1'b1;
          end
        end
        S_GAP: if (tmr == TM_W'(DESEL_CLKS - 1)) begin
          tmr <= '0;
          case (nx)
            N_WRITE: begin
              tx    <= mk_frame(2'b01, addr_q, wdata_q);
              bcnt  <= BC_W'(FRAME_W - 1);
              sel_q <= 1'b1;
              clk_q <= 1'b0;
              dcnt  <= '0;
              st    <= S_SHIFT;
            end
            N_POLL: begin
              sel_q <= 1'b1;
              st    <= S_POLL;
            end
            default: begin
              done <= 1'b1;
              err  <= err_f;
              st   <= S_IDLE;
            end
          endcase
        end else begin
          tmr <= tmr + 1'b1;
        end
        S_POLL: if (tmr != '0 && mem_miso) begin
          sel_q <= 1'b0;
          tmr   <= '0;
          nx    <= N_END;
          st    <= S_GAP;
        end else if (tmr == TM_W'(POLL_LIMIT)) begin
          err_f <= 1'b1;
          sel_q <= 1'b0;
          tmr   <= '0;
          nx    <= N_END;
          st    <= S_GAP;
        end else begin
          tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_eeprom_host_chk.sv
module uwire_eeprom_host_chk #(
  parameter int DESEL_CLKS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic done,
  input logic err,
  input logic mem_sel,
  input logic mem_clk,
  input logic mem_mosi
);
  localparam int LW = $clog2(DESEL_CLKS + 1) + 1;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)             low_run <= LW'(DESEL_CLKS);
    else if (mem_sel)       low_run <= '0;
    else if (low_run < LW'(DESEL_CLKS)) low_run <= low_run + 1'b1;
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !mem_sel |-> !mem_clk); // R3
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (mem_sel && mem_clk && $past(mem_clk)) |-> $stable(mem_mosi)); // R2
  AST_READY_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_sel); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_sel); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) err |-> done); // R8
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R4
  AST_DESEL_MIN: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_sel) |-> (low_run >= LW'(DESEL_CLKS))); // R10
endmodule

bind uwire_eeprom_host uwire_eeprom_host_chk #(.DESEL_CLKS(DESEL_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid), .done(done),
  .err(err), .mem_sel(mem_sel), .mem_clk(mem_clk), .mem_mosi(mem_mosi)
);

// File: tb/uwire_eeprom_host_tb.sv
module uwire_eeprom_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int A = 6, D = 16, LW = 4, HALF = 2, DESEL = 4, PLIM = 40, T_BUSY = 20;
  localparam int CMD = 3 + A, FW = CMD + D, DEPTH = 1 << A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_op = 1'b0;
  logic [A-1:0] req_addr = '0;
  logic [D-1:0] req_wdata = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, rd_valid, done, err, mem_sel, mem_clk, mem_mosi, mem_miso;
  logic [D-1:0] rd_data;

  int vectors = 0, fails = 0, cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uwire_eeprom_host #(.ADDR_W(A), .DATA_W(D), .LEN_W(LW), .HALF_DIV(HALF),
                      .DESEL_CLKS(DESEL), .POLL_LIMIT(PLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
    .mem_sel(mem_sel), .mem_clk(mem_clk), .mem_mosi(mem_mosi), .mem_miso(mem_miso));

  function automatic logic [D-1:0] init_pat(input int a);
    return D'(a * 499 + 2570);
  endfunction
  function automatic logic [D-1:0] wr_pat(input int a);
    return D'((a * 721) ^ 50010);
  endfunction

  logic [D-1:0] mem [DEPTH];
  logic [D-1:0] exp_mem [DEPTH];
  int mcnt, oidx, busy, clk_hi, sel_lo, unlock_cnt, wr_locked, clk_bad, desel_bad;
  logic [FW-1:0] msh;
  logic unlocked_m, reading, dout, wr_pend, clk_d, sel_d;
  logic [A-1:0] raddr, wr_a;
  logic [D-1:0] wr_d;
  bit stuck = 1'b0;
  wire [FW-1:0] nsh = {msh[FW-2:0], mem_mosi};

  assign mem_miso = !mem_sel ? 1'b0 : (mcnt == 0 ? (busy == 0 && !stuck) : dout);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_pat(i);
      mcnt <= 0; oidx <= 0; busy <= 0; clk_hi <= 0; sel_lo <= 100;
      unlock_cnt <= 0; wr_locked <= 0; clk_bad <= 0; desel_bad <= 0;
      msh <= '0; unlocked_m <= 1'b0; reading <= 1'b0; dout <= 1'b0; wr_pend <= 1'b0;
      clk_d <= 1'b0; sel_d <= 1'b0; raddr <= '0; wr_a <= '0; wr_d <= '0;
    end else begin
      clk_d <= mem_clk;
      sel_d <= mem_sel;
      if (busy > 0) busy <= busy - 1;
      clk_hi <= mem_clk ? clk_hi + 1 : 0;
      if (!mem_clk && clk_d && clk_hi != HALF) clk_bad <= clk_bad + 1;
      sel_lo <= mem_sel ? 0 : sel_lo + 1;
      if (mem_sel && !sel_d && sel_lo < DESEL) desel_bad <= desel_bad + 1;
      if (mem_sel && mem_clk && !clk_d) begin
        msh  <= nsh;
        mcnt <= mcnt + 1;
        if (reading) begin
          dout <= mem[raddr][oidx];
          if (oidx == 0) begin oidx <= D - 1; raddr <= raddr + 1'b1; end
          else oidx <= oidx - 1;
        end else if (mcnt == CMD - 1) begin
          if (nsh[CMD-1:CMD-3] == 3'b110) begin
            reading <= 1'b1; dout <= 1'b0; raddr <= nsh[A-1:0]; oidx <= D - 1;
          end
          if (nsh[CMD-1:0] == {3'b100, 2'b11, {(A-2){1'b0}}}) begin
            unlocked_m <= 1'b1; unlock_cnt <= unlock_cnt + 1;
          end
        end else if (mcnt == FW - 1 && nsh[FW-1:FW-3] == 3'b101) begin
          wr_pend <= 1'b1; wr_a <= nsh[D+A-1:D]; wr_d <= nsh[D-1:0];
        end
      end
      if (!mem_sel && sel_d) begin
        mcnt <= 0; reading <= 1'b0; msh <= '0;
        if (wr_pend) begin
          if (unlocked_m) mem[wr_a] <= wr_d;
          else wr_locked <= wr_locked + 1;
          wr_pend <= 1'b0;
          busy <= T_BUSY;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic op, input int a, input logic [D-1:0] d, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = A'(a); req_wdata = d; req_len = LW'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && mem_sel, "R9 busy after accept", {req_ready, mem_sel}, 2'b01);
  endtask

  task automatic do_write(input int a, input logic [D-1:0] d, input bit expect_err);
    int cyc = 0;
    issue(1'b1, a, d, 0);
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    if (expect_err) begin
      chk(done && err, "R8 timeout error with done", {done, err}, 2'b11);
      chk(cyc >= PLIM, "R8 poll ran to limit", cyc, PLIM);
    end else begin
      chk(done && !err, "R7 write done without error", {done, err}, 2'b10);
      chk(busy == 0, "R7 done only after ready", busy, 0);
    end
    exp_mem[a] = d;
  endtask

  task automatic do_read(input int a, input int len);
    int cyc = 0, n = 0;
    issue(1'b0, a, '0, len);
    while (!done && cyc < 20000) begin
      @(negedge clk); cyc++;
      if (rd_valid) begin
        chk(rd_data == exp_mem[(a + n) % DEPTH], len == 0 ? "R4 single read word" : "R5 burst word",
            rd_data, exp_mem[(a + n) % DEPTH]);
        n++;
      end
    end
    chk(done && !err, "R9 read done", {done, err}, 2'b10);
    chk(n == len + 1, "R5 word count", n, len + 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_sel && !mem_clk, "R1 reset select and clock", {mem_sel, mem_clk}, 0);
    chk(req_ready, "R1 reset ready", req_ready, 1);
    chk(!done && !err && !rd_valid, "R1 reset strobes", {done, err, rd_valid}, 0);

    for (int a = 0; a < DEPTH; a++)
      if (a % 2 == 0 || a == DEPTH - 1) do_write(a, wr_pat(a), 1'b0);
    chk(unlock_cnt == 1, "R6 unlock sent once", unlock_cnt, 1);
    chk(wr_locked == 0, "R6 no write while locked", wr_locked, 0);

    for (int a = 0; a < DEPTH; a++) do_read(a, 0);
    do_read(0, 15);
    do_read(DEPTH - 7, 12);
    do_read(DEPTH - 1, 1);
    do_read(30, 7);

    stuck = 1'b1;
    do_write(5, 16'h1234, 1'b1);
    stuck = 1'b0;
    repeat (T_BUSY + 2) @(negedge clk);
    do_write(9, 16'hBEEF, 1'b0);
    do_read(3, 7);
    chk(unlock_cnt == 1, "R6 unlock not repeated", unlock_cnt, 1);
    chk(clk_bad == 0, "R3 clock high width", clk_bad, 0);
    chk(desel_bad == 0, "R10 deselect width", desel_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule